// File: doc/BRIEF.md
# Fine-Bin Non-Linearity Corrector

This block takes raw time-to-digital converter timestamps and removes the integral non-linearity that the converter leaves in each of its fine bins. The low fine bits of every timestamp select one entry of a writable correction table. Each entry is a signed offset in quarter-LSB units. The result is the raw value scaled by four with that offset added. Each corrected timestamp therefore carries two extra fractional bits, about 6.1 ps when the LSB is 24.4 ps.

The non-linearity pattern repeats from channel to channel, so a single table serves every timestamp that passes through. A host loads the table through a simple write port, and may do so while timestamps are flowing. A write never disturbs a lookup that is in progress. A bypass input turns off the correction, and the block then outputs the raw value scaled by four.

Top module: `inl_fine_corrector`

## Requirements
- R1: After reset, out_valid is 0, out_ts is 0 and every table entry is zero, so an uncorrected timestamp returns raw×4.
- R2: For a valid input with bypass at 0, out_ts equals in_ts×4 plus the sign-extended entry addressed by in_ts[FINE_W-1:0]. The entry is two's complement, CORR_W bits wide, in quarter-LSB units.
- R3: out_valid rises on the first clock edge after in_valid is sampled high, and at that edge out_ts holds that sample's result.
- R4: A negative correction that takes the result below zero wraps modulo 2^(TS_W+2). The borrow is taken from the coarse count above the fine bits.
- R5: A positive correction that carries past the top of the output range wraps modulo 2^(TS_W+2).
- R6: With bypass at 1 on a valid input, out_ts equals in_ts×4 whatever the table holds.
- R7: A table write in the same cycle as a lookup of the same entry does not affect that lookup, which uses the old entry. The next lookup uses the new entry.
- R8: On a cycle with in_valid low, the next edge drives out_valid to 0 and leaves out_ts unchanged.
- R9: The correction depends only on the fine bits. Timestamps with different coarse counts and the same fine bits receive the same offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Raw timestamp present |
| in_ts | input | TS_W | Raw timestamp, fine bits at the bottom |
| bypass | input | 1 | Skip correction, output raw×4 |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | FINE_W | Table entry to write |
| wr_data | input | CORR_W | Signed quarter-LSB correction |
| out_valid | output | 1 | Corrected timestamp present |
| out_ts | output | TS_W+2 | Corrected timestamp, two fractional bits |

## Verification
Every corrected timestamp is due exactly one clock edge after its input is sampled. The bench drives inputs on the falling edge and reads the outputs shortly after the next rising edge. A table write takes effect at its own edge, so the check for R7 pairs a write with a lookup in the same cycle and then runs a second lookup one cycle later. Each of the two lookups is checked at its own following edge. The hold check for R8 samples one idle edge after a valid result.

// File: rtl/inl_pkg.sv
// Shared constants for the fine-bin corrector.
// Assumes corrections are expressed in quarter-LSB units.
package inl_pkg;
    localparam int FRAC_W = 2;   // fractional bits added by quarter-LSB entries
endpackage

// File: rtl/inl_table.sv
// Correction table: one signed entry per fine bin, cleared by reset,
// written by the host and read combinationally.
// Assumes a read in the same cycle as a write returns the old entry.
module inl_table #(
    parameter int FINE_W = 10,
    parameter int CORR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FINE_W-1:0] wr_addr,
    input  logic [CORR_W-1:0] wr_data,
    input  logic [FINE_W-1:0] rd_addr,
    output logic [CORR_W-1:0] rd_data
);
    localparam int DEPTH = 1 << FINE_W;

    logic [CORR_W-1:0] mem [DEPTH];

    // Clear all entries on reset; otherwise apply host writes at the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Combinational read of the addressed entry (old value during a write).
    always_comb rd_data = mem[rd_addr];

    // R7: a write is visible at its address one cycle later.
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/inl_apply.sv
// Scales the raw timestamp by four, adds the sign-extended correction
// and registers the result together with its valid flag.
// Assumes CORR_W is less than the output width; wrap is modulo the output width.
module inl_apply #(
    parameter int TS_W   = 21,
    parameter int CORR_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [TS_W-1:0]                   in_ts,
    input  logic                              bypass,
    input  logic [CORR_W-1:0]                 corr,
    output logic                              out_valid,
    output logic [TS_W+inl_pkg::FRAC_W-1:0]   out_ts
);
    localparam int OUT_W = TS_W + inl_pkg::FRAC_W;

    logic [OUT_W-1:0] scaled;
    logic [OUT_W-1:0] offset;

    // Raw value in quarter-LSB units and the widened correction.
    always_comb begin
        scaled = {in_ts, {inl_pkg::FRAC_W{1'b0}}};
        offset = bypass ? '0 : {{(OUT_W-CORR_W){corr[CORR_W-1]}}, corr};
    end

    // Single output register; the result holds while no timestamp arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ts    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_ts <= scaled + offset;
        end
    end

    // R3: valid follows the input one cycle later.
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R6: bypassed timestamps come out as raw times four.
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bypass) |=> out_ts == {$past(in_ts), {inl_pkg::FRAC_W{1'b0}}});
    // R8: idle cycles leave the result in place and drop valid.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_ts)));
endmodule

// File: rtl/inl_fine_corrector.sv
// Top of the fine-bin non-linearity corrector: the table is indexed by
// the fine bits of the raw timestamp, and the apply stage registers the result.
// Assumes one shared table for all channels and one-cycle latency.
module inl_fine_corrector #(
    parameter int TS_W   = 21,
    parameter int FINE_W = 10,
    parameter int CORR_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [TS_W-1:0]                 in_ts,
    input  logic                            bypass,
    input  logic                            wr_en,
    input  logic [FINE_W-1:0]               wr_addr,
    input  logic [CORR_W-1:0]               wr_data,
    output logic                            out_valid,
    output logic [TS_W+inl_pkg::FRAC_W-1:0] out_ts
);
    logic [FINE_W-1:0] fine_idx;
    logic [CORR_W-1:0] corr;

    // Fine bin selects the table entry.
    always_comb fine_idx = in_ts[FINE_W-1:0];

    inl_table #(.FINE_W(FINE_W), .CORR_W(CORR_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (fine_idx),
        .rd_data (corr)
    );

    inl_apply #(.TS_W(TS_W), .CORR_W(CORR_W)) u_apply (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ts     (in_ts),
        .bypass    (bypass),
        .corr      (corr),
        .out_valid (out_valid),
        .out_ts    (out_ts)
    );

    // R1: out of reset nothing is reported valid.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/sim_inl_fine_corrector.sv
module sim_inl_fine_corrector;
    localparam int TS_W   = 21;
    localparam int FINE_W = 10;
    localparam int CORR_W = 8;
    localparam int OUT_W  = TS_W + 2;

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic [TS_W-1:0] in_ts = '0;
    logic bypass = 0;
    logic wr_en = 0;
    logic [FINE_W-1:0] wr_addr = '0;
    logic [CORR_W-1:0] wr_data = '0;
    logic out_valid;
    logic [OUT_W-1:0] out_ts;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    inl_fine_corrector #(.TS_W(TS_W), .FINE_W(FINE_W), .CORR_W(CORR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ts(in_ts),
        .bypass(bypass), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_ts(out_ts)
    );

    // Vectors, applied after loading: entry3=+5, entry10=-3, entry0=-128, entry1023=+127.
    localparam int NV = 8;
    localparam int    V_TS  [NV] = '{3, 1027, 10, 0, 1024, 2097151, 3, 5};
    localparam bit    V_BYP [NV] = '{0, 0, 0, 0, 0, 0, 1, 0};
    localparam int    V_EXP [NV] = '{17, 4113, 37, 8388480, 3968, 123, 12, 20};
    localparam string V_REQ [NV] = '{"R2", "R9", "R2", "R4", "R4", "R5", "R6", "R2"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_entry(input int addr, input logic [CORR_W-1:0] val);
        @(negedge clk);
        wr_en = 1; wr_addr = addr[FINE_W-1:0]; wr_data = val;
        @(negedge clk);
        wr_en = 0;
    endtask

    // Present one timestamp and check the result one edge later.
    task automatic lookup(input int ts, input bit byp, input int exp, input string req);
        @(negedge clk);
        in_valid = 1; in_ts = ts[TS_W-1:0]; bypass = byp;
        @(posedge clk); #1;
        check(req, {31'd0, out_valid}, 32'd1);
        check(req, {{(32-OUT_W){1'b0}}, out_ts}, exp);
        @(negedge clk);
        in_valid = 0; bypass = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet during reset
        check("R1", {31'd0, out_valid}, 32'd0);
        check("R1", {{(32-OUT_W){1'b0}}, out_ts}, 32'd0);
        @(negedge clk); rst_n = 1;
        // R1: cleared table gives raw x4
        lookup(3, 0, 12, "R1");
        lookup(1023, 0, 4092, "R1");

        write_entry(3, 8'd5);
        write_entry(10, 8'hFD);
        write_entry(0, 8'h80);
        write_entry(1023, 8'h7F);

        for (int i = 0; i < NV; i++) lookup(V_TS[i], V_BYP[i], V_EXP[i], V_REQ[i]);

        // R8: an idle edge drops valid and keeps the last result (20)
        @(posedge clk); #1;
        check("R8", {31'd0, out_valid}, 32'd0);
        check("R8", {{(32-OUT_W){1'b0}}, out_ts}, 32'd20);

        // R7: write entry 7 = +4 in the same cycle as a lookup of fine bin 7
        @(negedge clk);
        in_valid = 1; in_ts = 7; wr_en = 1; wr_addr = 7; wr_data = 8'd4;
        @(posedge clk); #1;
        check("R7", {{(32-OUT_W){1'b0}}, out_ts}, 32'd28);
        @(negedge clk);
        wr_en = 0;
        @(posedge clk); #1;
        check("R7", {{(32-OUT_W){1'b0}}, out_ts}, 32'd32);
        @(negedge clk);
        in_valid = 0;

        // R3: a single-cycle input gives a single-cycle valid
        @(posedge clk); #1;
        check("R3", {31'd0, out_valid}, 32'd0);

        // R1: reset again clears the table
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1;
        check("R1", {31'd0, out_valid}, 32'd0);
        @(negedge clk); rst_n = 1;
        lookup(3, 0, 12, "R1");

        done = 1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule